// File: doc/BRIEF.md
# Coherence Fill Response Handler

This block decides how a cache controller reacts when the system answers one of its outstanding block requests. Three request classes are tracked: read-for-modify (the block is fetched so it can be written), change-to-dirty (a cached copy asks for write permission), and invalidate-to-dirty (a whole-block write hint asks for ownership without data). Each answer pairs a request class with a response code. The pair selects a fixed set of actions: per-entry state updates, a retry with a chosen next command, forced failure or success of a pending conditional store, an all-ones load return with eviction, a machine check, or an illegal-response flag.

A response arrives as a one-cycle strobe. The strobe carries the pending-miss index, the request class and the response code. It also carries three facts from the miss entry: whether the originating store is still live, whether a probe has invalidated the block, and whether a conditional store is pending. The action outputs are registered and pulse for one cycle, starting one clock after the strobe. The per-entry valid, writable and victim-on-evict bits change on that same edge and are visible as vectors.

A livelock-avoidance enable input governs every retry that would issue a change-to-dirty command. When it is clear, a stall/error pulse is raised instead of that retry.

Top module: `coh_fill_resp`

## Requirements
- R1: After reset every action output is 0 and all entry bits (blk_valid, blk_writable, blk_victim) are 0.
- R2: Encodings are: req_cls 0 = read-for-modify, 1 = change-to-dirty, 2 = invalidate-to-dirty, 3 = reserved. rsp_code 0 = read, 1 = read-shared, 2 = read-shared-dirty, 3 = read-dirty, 4 = change-ok, 5 = change-fail, 6 = read-error, 7 = reserved. A read-for-modify answered with code 0, 1 or 2 sets the entry valid and not writable, and sets victim only for code 2. If store_live is 1, it requests a retry with retry_cls 1.
- R3: A read-for-modify answered with read-dirty sets the entry valid, writable and not victim, with no retry.
- R4: The pairs read-for-modify with change-ok or change-fail, change-to-dirty with read-error, invalidate-to-dirty with change-fail, any reserved class and any reserved code raise only illegal_rsp. They leave the entry bits unchanged.
- R5: A read-for-modify answered with read-error pulses ld_ones and evict_req and clears all three entry bits. It pulses stc_fail if stc_pend is 1, and never retries.
- R6: A change-to-dirty answered with code 0, 1 or 2 sets the entry valid and not writable, with victim equal to (code == 2). It pulses stc_fail when stc_pend is 1, and retries with class 1 when store_live is 1.
- R7: A change-to-dirty answered with read-dirty sets the entry valid, writable and victim. It pulses stc_fail when stc_pend is 1, with no retry.
- R8: A change-to-dirty answered with change-ok sets the entry valid and writable and keeps victim. It pulses st_replay, sets stc_allow equal to stc_pend, and never pulses stc_fail.
- R9: A change-to-dirty answered with change-fail pulses retire and pulses stc_fail when stc_pend is 1. When store_live is 1 it retries with class 0 if probe_inval is 1, else with class 1. If probe_inval is 1, it also clears all three entry bits; otherwise they are unchanged.
- R10: An invalidate-to-dirty answered with code 0, 1 or 2 sets the entry valid and not writable, with victim equal to (code == 2). It always retries with class 1.
- R11: An invalidate-to-dirty answered with read-dirty or change-ok makes the entry valid and writable with no retry. Read-dirty clears victim; change-ok keeps it. Answered with read-error, it pulses mchk_err and leaves the entry bits unchanged.
- R12: When livelock_en is 0, a retry with class 1 is suppressed and ll_stall pulses in its place. A retry with class 0 is unaffected.
- R13: Actions appear exactly one clock after the strobe, for one cycle, with act_vld = 1 and act_idx equal to the strobed index. Without a strobe, all action outputs are 0 and no entry bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_vld | input | 1 | Response strobe |
| rsp_idx | input | IW | Pending-miss index of the response |
| req_cls | input | 2 | Class of the original request |
| rsp_code | input | 3 | System response code |
| store_live | input | 1 | Originating store not killed |
| probe_inval | input | 1 | A probe invalidated the block |
| stc_pend | input | 1 | Conditional store pending on the block |
| livelock_en | input | 1 | Permits change-to-dirty retries |
| act_vld | output | 1 | Action outputs valid |
| act_idx | output | IW | Index the actions refer to |
| retry_req | output | 1 | Issue a retry command |
| retry_cls | output | 2 | Class of the retry command |
| ll_stall | output | 1 | Retry suppressed, stall/error |
| st_replay | output | 1 | Replay the store into the cache |
| stc_fail | output | 1 | Force conditional store to fail |
| stc_allow | output | 1 | Allow conditional store to succeed |
| ld_ones | output | 1 | Return all ones to dependent loads |
| evict_req | output | 1 | Evict block with victim processing |
| retire | output | 1 | Retire the pending-miss entry |
| mchk_err | output | 1 | Machine-check hard error |
| illegal_rsp | output | 1 | Response illegal for the request |
| blk_valid | output | NENT | Per-entry valid bits |
| blk_writable | output | NENT | Per-entry writable bits |
| blk_victim | output | NENT | Per-entry victim-on-evict bits |

## Verification
The livelock stall and the forced conditional-store failure can land in the same cycle. This happens when a change-to-dirty request, with a conditional store pending, is answered with shared data while livelock_en is clear. The bench sets up exactly that and expects ll_stall and stc_fail together, with no retry. A second overlap is two back-to-back strobes to different entries: each result must appear in its own cycle with its own index, and neither may disturb the other entry's bits.

// File: rtl/coh_fill_resp.sv
module coh_fill_resp #(
  parameter int NENT = 8,
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rsp_vld,
  input  logic [IW-1:0]   rsp_idx,
  input  logic [1:0]      req_cls,
  input  logic [2:0]      rsp_code,
  input  logic            store_live,
  input  logic            probe_inval,
  input  logic            stc_pend,
  input  logic            livelock_en,
  output logic            act_vld,
  output logic [IW-1:0]   act_idx,
  output logic            retry_req,
  output logic [1:0]      retry_cls,
  output logic            ll_stall,
  output logic            st_replay,
  output logic            stc_fail,
  output logic            stc_allow,
  output logic            ld_ones,
  output logic            evict_req,
  output logic            retire,
  output logic            mchk_err,
  output logic            illegal_rsp,
  output logic [NENT-1:0] blk_valid,
  output logic [NENT-1:0] blk_writable,
  output logic [NENT-1:0] blk_victim
);
  localparam logic [1:0] C_RDMOD = 2'd0, C_CTD = 2'd1, C_ITD = 2'd2;
  localparam logic [2:0] R_SHD = 3'd2, R_DTY = 3'd3, R_OK = 3'd4,
                         R_FAIL = 3'd5, R_ERR = 3'd6;

  logic is_rd, cur_x;
  logic upd, nv, nw, nx;
  logic want, force_f, ill, ones, evc, rep, alw, ret, mchk;
  logic [1:0] wcls;
  logic blocked;

  assign is_rd = (rsp_code <= R_SHD);
  assign cur_x = blk_victim[rsp_idx];

  always_comb begin
    upd = 1'b0; nv = 1'b0; nw = 1'b0; nx = 1'b0;
    want = 1'b0; wcls = C_CTD; force_f = 1'b0; ill = 1'b0;
    ones = 1'b0; evc = 1'b0; rep = 1'b0; alw = 1'b0; ret = 1'b0; mchk = 1'b0;
    case (req_cls)
      C_RDMOD: begin
        if (is_rd) begin
          upd = 1'b1; nv = 1'b1; nx = (rsp_code == R_SHD);
          want = store_live;
        end else if (rsp_code == R_DTY) begin
          upd = 1'b1; nv = 1'b1; nw = 1'b1;
        end else if (rsp_code == R_ERR) begin
          upd = 1'b1; ones = 1'b1; evc = 1'b1; force_f = 1'b1;
        end else begin
          ill = 1'b1;
        end
      end
      C_CTD: begin
        if (is_rd) begin
          upd = 1'b1; nv = 1'b1; nx = (rsp_code == R_SHD);
          want = store_live; force_f = 1'b1;
        end else if (rsp_code == R_DTY) begin
          upd = 1'b1; nv = 1'b1; nw = 1'b1; nx = 1'b1; force_f = 1'b1;
        end else if (rsp_code == R_OK) begin
          upd = 1'b1; nv = 1'b1; nw = 1'b1; nx = cur_x;
          rep = 1'b1; alw = stc_pend;
        end else if (rsp_code == R_FAIL) begin
          ret = 1'b1; force_f = 1'b1; want = store_live;
          wcls = probe_inval ? C_RDMOD : C_CTD;
          upd = probe_inval;
        end else begin
          ill = 1'b1;
        end
      end
      C_ITD: begin
        if (is_rd) begin
          upd = 1'b1; nv = 1'b1; nx = (rsp_code == R_SHD); want = 1'b1;
        end else if (rsp_code == R_DTY) begin
          upd = 1'b1; nv = 1'b1; nw = 1'b1;
        end else if (rsp_code == R_OK) begin
          upd = 1'b1; nv = 1'b1; nw = 1'b1; nx = cur_x;
        end else if (rsp_code == R_ERR) begin
          mchk = 1'b1;
        end else begin
          ill = 1'b1;
        end
      end
      default: ill = 1'b1;
    endcase
  end

  assign blocked = want && (wcls == C_CTD) && !livelock_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_vld <= 1'b0; act_idx <= '0; retry_req <= 1'b0; retry_cls <= 2'd0;
      ll_stall <= 1'b0; st_replay <= 1'b0; stc_fail <= 1'b0; stc_allow <= 1'b0;
      ld_ones <= 1'b0; evict_req <= 1'b0; retire <= 1'b0; mchk_err <= 1'b0;
      illegal_rsp <= 1'b0;
      blk_valid <= '0; blk_writable <= '0; blk_victim <= '0;
    end else begin
      act_vld     <= rsp_vld;
      act_idx     <= rsp_vld ? rsp_idx : '0;
      retry_req   <= rsp_vld && want && !blocked;
      retry_cls   <= (rsp_vld && want && !blocked) ? wcls : 2'd0;
      ll_stall    <= rsp_vld && blocked;
      st_replay   <= rsp_vld && rep;
      stc_fail    <= rsp_vld && force_f && stc_pend;
      stc_allow   <= rsp_vld && alw;
      ld_ones     <= rsp_vld && ones;
      evict_req   <= rsp_vld && evc;
      retire      <= rsp_vld && ret;
      mchk_err    <= rsp_vld && mchk;
      illegal_rsp <= rsp_vld && ill;
      if (rsp_vld && upd) begin
        blk_valid[rsp_idx]    <= nv;
        blk_writable[rsp_idx] <= nw;
        blk_victim[rsp_idx]   <= nx;
      end
    end
  end
endmodule

module coh_fill_resp_chk #(
  parameter int NENT = 8,
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rsp_vld,
  input logic [IW-1:0]   rsp_idx,
  input logic [1:0]      req_cls,
  input logic            livelock_en,
  input logic            act_vld,
  input logic [IW-1:0]   act_idx,
  input logic            retry_req,
  input logic [1:0]      retry_cls,
  input logic            ll_stall,
  input logic            st_replay,
  input logic            stc_fail,
  input logic            stc_allow,
  input logic            ld_ones,
  input logic            evict_req,
  input logic            retire,
  input logic            mchk_err,
  input logic            illegal_rsp,
  input logic [NENT-1:0] blk_valid,
  input logic [NENT-1:0] blk_writable,
  input logic [NENT-1:0] blk_victim
);
  logic any_act;
  assign any_act = retry_req || ll_stall || st_replay || stc_fail || stc_allow ||
                   ld_ones || evict_req || retire || mchk_err;

  assert_stc_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stc_fail && stc_allow));
  assert_ctd_retry_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req && retry_cls == 2'd1) |-> $past(livelock_en));
  assert_stall_no_retry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ll_stall |-> !retry_req);
  assert_illegal_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rsp |-> !any_act);
  assert_illegal_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rsp |-> (blk_valid == $past(blk_valid) && blk_writable == $past(blk_writable)
                     && blk_victim == $past(blk_victim)));
  assert_ones_evict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ones |-> (evict_req && !blk_valid[act_idx]));
  assert_mchk_itd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_err |-> $past(req_cls) == 2'd2);
  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rsp_vld) |-> (!act_vld && !any_act && !illegal_rsp));
  assert_idx_echo_R13: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |-> act_idx == $past(rsp_idx));
endmodule

bind coh_fill_resp coh_fill_resp_chk #(.NENT(NENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_vld(rsp_vld), .rsp_idx(rsp_idx), .req_cls(req_cls),
  .livelock_en(livelock_en), .act_vld(act_vld), .act_idx(act_idx),
  .retry_req(retry_req), .retry_cls(retry_cls), .ll_stall(ll_stall),
  .st_replay(st_replay), .stc_fail(stc_fail), .stc_allow(stc_allow),
  .ld_ones(ld_ones), .evict_req(evict_req), .retire(retire), .mchk_err(mchk_err),
  .illegal_rsp(illegal_rsp), .blk_valid(blk_valid), .blk_writable(blk_writable),
  .blk_victim(blk_victim));

// File: tb/coh_fill_resp_bench.sv
`timescale 1ns/1ps
module coh_fill_resp_bench;
  localparam int NENT = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rsp_vld = 1'b0, store_live = 1'b0, probe_inval = 1'b0, stc_pend = 1'b0;
  logic livelock_en = 1'b1;
  logic [IW-1:0] rsp_idx = '0;
  logic [1:0] req_cls = '0;
  logic [2:0] rsp_code = '0;
  logic act_vld, retry_req, ll_stall, st_replay, stc_fail, stc_allow;
  logic ld_ones, evict_req, retire, mchk_err, illegal_rsp;
  logic [IW-1:0] act_idx;
  logic [1:0] retry_cls;
  logic [NENT-1:0] blk_valid, blk_writable, blk_victim;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  coh_fill_resp #(.NENT(NENT)) u_coh_fill_resp (.*);

  // action vector: {retry_req, retry_cls, ll_stall, st_replay, stc_fail,
  //                 stc_allow, ld_ones, evict_req, retire, mchk_err, illegal_rsp}
  function automatic logic [11:0] actv();
    return {retry_req, retry_cls, ll_stall, st_replay, stc_fail, stc_allow,
            ld_ones, evict_req, retire, mchk_err, illegal_rsp};
  endfunction

  function automatic logic [11:0] mk(bit rt, logic [1:0] c, bit stl, bit rp, bit sf,
      bit sa, bit on, bit ev, bit re, bit mc, bit il);
    return {rt, c, stl, rp, sf, sa, on, ev, re, mc, il};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_st(string req, int i, logic [2:0] exp);
    chk(req, {29'd0, blk_valid[i], blk_writable[i], blk_victim[i]}, {29'd0, exp});
  endtask

  task automatic send(int i, logic [1:0] c, logic [2:0] r, bit lv, bit pb, bit sp);
    @(negedge clk);
    rsp_vld = 1'b1; rsp_idx = IW'(i); req_cls = c; rsp_code = r;
    store_live = lv; probe_inval = pb; stc_pend = sp;
    @(negedge clk);
    rsp_vld = 1'b0; store_live = 0; probe_inval = 0; stc_pend = 0;
  endtask

  task automatic t_reset();
    chk("R1 actions", {20'd0, actv()}, 32'd0);
    chk("R1 valid", {24'd0, blk_valid}, 32'd0);
    chk("R1 writable", {24'd0, blk_writable}, 32'd0);
    chk("R1 victim", {24'd0, blk_victim}, 32'd0);
  endtask

  task automatic t_rdmod();
    send(1, 2'd0, 3'd0, 1, 0, 1);
    chk("R2 rd act", {20'd0, actv()}, {20'd0, mk(1,2'd1,0,0,0,0,0,0,0,0,0)});
    chk_st("R2 rd state", 1, 3'b100);
    send(2, 2'd0, 3'd2, 0, 0, 0);
    chk("R2 shd no live act", {20'd0, actv()}, 32'd0);
    chk_st("R2 shd state", 2, 3'b101);
    send(3, 2'd0, 3'd3, 1, 0, 1);
    chk("R3 dirty act", {20'd0, actv()}, 32'd0);
    chk_st("R3 dirty state", 3, 3'b110);
  endtask

  task automatic t_rdmod_err();
    send(1, 2'd0, 3'd6, 1, 0, 1);
    chk("R5 err act", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,0,1,0,1,1,0,0,0)});
    chk_st("R5 err state", 1, 3'b000);
    send(2, 2'd0, 3'd6, 0, 0, 0);
    chk("R5 err no pend", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,0,0,0,1,1,0,0,0)});
    chk_st("R5 err state2", 2, 3'b000);
  endtask

  task automatic t_ctd();
    send(4, 2'd1, 3'd1, 1, 0, 1);
    chk("R6 sh act", {20'd0, actv()}, {20'd0, mk(1,2'd1,0,0,1,0,0,0,0,0,0)});
    chk_st("R6 sh state", 4, 3'b100);
    send(4, 2'd1, 3'd2, 0, 0, 0);
    chk("R6 shd act", {20'd0, actv()}, 32'd0);
    chk_st("R6 shd state", 4, 3'b101);
    send(5, 2'd1, 3'd3, 1, 0, 1);
    chk("R7 dirty act", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,0,1,0,0,0,0,0,0)});
    chk_st("R7 dirty state", 5, 3'b111);
  endtask

  task automatic t_ctd_ok();
    send(4, 2'd1, 3'd4, 1, 0, 1);
    chk("R8 ok act", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,1,0,1,0,0,0,0,0)});
    chk_st("R8 ok state", 4, 3'b111);
    send(4, 2'd1, 3'd4, 1, 0, 0);
    chk("R8 ok no pend", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,1,0,0,0,0,0,0,0)});
  endtask

  task automatic t_ctd_fail();
    send(5, 2'd1, 3'd5, 1, 0, 1);
    chk("R9 fail ctd", {20'd0, actv()}, {20'd0, mk(1,2'd1,0,0,1,0,0,0,1,0,0)});
    chk_st("R9 fail keep", 5, 3'b111);
    send(5, 2'd1, 3'd5, 1, 1, 0);
    chk("R9 fail probe", {20'd0, actv()}, {20'd0, mk(1,2'd0,0,0,0,0,0,0,1,0,0)});
    chk_st("R9 fail inval", 5, 3'b000);
    send(5, 2'd1, 3'd5, 0, 0, 0);
    chk("R9 fail dead store", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,0,0,0,0,0,1,0,0)});
  endtask

  task automatic t_itd();
    send(6, 2'd2, 3'd0, 0, 0, 0);
    chk("R10 rd act", {20'd0, actv()}, {20'd0, mk(1,2'd1,0,0,0,0,0,0,0,0,0)});
    chk_st("R10 rd state", 6, 3'b100);
    send(7, 2'd2, 3'd2, 0, 0, 0);
    chk_st("R10 shd state", 7, 3'b101);
    send(7, 2'd2, 3'd4, 0, 0, 0);
    chk("R11 ok act", {20'd0, actv()}, 32'd0);
    chk_st("R11 ok keeps victim", 7, 3'b111);
    send(6, 2'd2, 3'd3, 0, 0, 0);
    chk("R11 dirty act", {20'd0, actv()}, 32'd0);
    chk_st("R11 dirty state", 6, 3'b110);
    send(6, 2'd2, 3'd6, 1, 0, 1);
    chk("R11 mchk act", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,0,0,0,0,0,0,1,0)});
    chk_st("R11 mchk state", 6, 3'b110);
  endtask

  task automatic t_illegal();
    logic [1:0] cl [6] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd1};
    logic [2:0] cd [6] = '{3'd4, 3'd5, 3'd6, 3'd5, 3'd0, 3'd7};
    for (int k = 0; k < 6; k++) begin
      send(3, cl[k], cd[k], 1, 1, 1);
      chk("R4 illegal act", {20'd0, actv()}, {20'd0, mk(0,2'd0,0,0,0,0,0,0,0,0,1)});
      chk_st("R4 illegal state", 3, 3'b110);
    end
  endtask

  task automatic t_livelock();
    livelock_en = 1'b0;
    send(0, 2'd0, 3'd0, 1, 0, 0);
    chk("R12 rdmod stall", {20'd0, actv()}, {20'd0, mk(0,2'd0,1,0,0,0,0,0,0,0,0)});
    chk_st("R12 state", 0, 3'b100);
    send(0, 2'd1, 3'd5, 1, 1, 0);
    chk("R12 rdmod retry free", {20'd0, actv()}, {20'd0, mk(1,2'd0,0,0,0,0,0,0,1,0,0)});
    send(0, 2'd1, 3'd1, 1, 0, 1);
    chk("R12 stall with stc fail", {20'd0, actv()}, {20'd0, mk(0,2'd0,1,0,1,0,0,0,0,0,0)});
    livelock_en = 1'b1;
  endtask

  task automatic t_timing();
    send(2, 2'd0, 3'd3, 0, 0, 0);
    chk("R13 vld", {31'd0, act_vld}, 32'd1);
    chk("R13 idx", {29'd0, act_idx}, 32'd2);
    @(negedge clk);
    chk("R13 pulse ends", {19'd0, act_vld, actv()}, 32'd0);
    chk_st("R13 idle keeps", 2, 3'b110);
    // back to back strobes
    rsp_vld = 1; rsp_idx = 3'd1; req_cls = 2'd0; rsp_code = 3'd3;
    @(negedge clk);
    rsp_idx = 3'd4; req_cls = 2'd1; rsp_code = 3'd1; store_live = 1; stc_pend = 1;
    chk("R13 b2b first idx", {29'd0, act_idx}, 32'd1);
    chk("R13 b2b first act", {20'd0, actv()}, 32'd0);
    @(negedge clk);
    rsp_vld = 0; store_live = 0; stc_pend = 0;
    chk("R13 b2b second idx", {29'd0, act_idx}, 32'd4);
    chk("R13 b2b second act", {20'd0, actv()}, {20'd0, mk(1,2'd1,0,0,1,0,0,0,0,0,0)});
    chk_st("R13 b2b entry1", 1, 3'b110);
    chk_st("R13 b2b entry4", 4, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rdmod();
    t_rdmod_err();
    t_ctd();
    t_ctd_ok();
    t_ctd_fail();
    t_itd();
    t_illegal();
    t_livelock();
    t_timing();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule